// File: doc/BRIEF.md
# Cartridge Freeze Sequencer

This block sits on a plug-in cartridge and stops a running 8-bit processor when the user presses a freeze button. It first pulls the bus-available line low to ask the processor to stop. It then switches the machine into game-console memory mode, which puts cartridge ROM at the top of memory. Last, it raises a non-maskable interrupt and lets the bus go, so that the processor enters the cartridge's freeze routine.

Every output is a drive enable for an open-drain line. When an enable is 1, the cartridge pulls that line low. When it is 0, the cartridge leaves the line alone and pull-ups hold it high. The processor keeps running through write cycles even while bus-available is low. For that reason the memory switch waits until the processor has made a run of consecutive read cycles, which shows that it has really stopped. Freeze software ends the freeze by pulsing the release input.

Top module: `freeze_seq`

## Requirements
- R1: After reset, every drive enable is 0. A button that is already high when reset is released does not count as a press; the button must first be seen low.
- R2: The button input is asynchronous and passes through two synchroniser flops. A rising edge on it sets `ba_oe` to 1 on the third rising clock edge after the button goes high.
- R3: While `ba_oe` is 1, `game_oe` stays 0 until `READS_NEEDED` (3 by default) consecutive cycles have `cpu_rw` = 1 (1 means read). A cycle with `cpu_rw` = 0 restarts the count. The switch happens on the clock edge that samples the last read of the run.
- R4: Game-console mode is selected by setting `game_oe` to 1 while `ba_oe` stays 1. `exrom_oe` is always 0, so that line is never pulled low.
- R5: On the first clock edge after the switch where `nmi_line_n` is 1, `nmi_oe` becomes 1 and `ba_oe` becomes 0 in the same cycle. `game_oe` stays 1.
- R6: While `nmi_line_n` is 0 (held low by another source), the block stays in the switched state with `ba_oe` and `game_oe` at 1 and `nmi_oe` at 0.
- R7: Once `nmi_oe` is 1, it stays at 1 until a release. Button presses have no effect while a freeze is in progress.
- R8: In the frozen state (`nmi_oe` = 1), `release_i` = 1 clears all enables on the next clock edge. In any other state, `release_i` is ignored.
- R9: After a release, a new rising edge of the button starts the sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | 1 | Debounced freeze button, asynchronous, high when pressed |
| cpu_rw | input | 1 | Processor read/write strobe, 1 = read |
| nmi_line_n | input | 1 | Sensed level of the shared NMI line |
| release_i | input | 1 | One-cycle pulse from a software write to the release register |
| ba_oe | output | 1 | Pull bus-available low |
| game_oe | output | 1 | Pull the game-mode configuration line low |
| exrom_oe | output | 1 | Pull the external-ROM configuration line low (always 0) |
| nmi_oe | output | 1 | Pull the NMI line low |

## Verification
The bench goes after these corner cases:
- A write that breaks a run of reads just short of the required count. A design that counts reads in total, rather than in a row, would switch memory while a write is still in flight.
- An NMI line that another source holds low at the moment of the switch. A design that ignores this would assert NMI into a line that is already low, so the processor takes no interrupt while the ROM is left mapped in.
- Button edges and release pulses that arrive in the wrong state. A design that honoured them would restart a freeze halfway or drop the mapping before the interrupt.
- A button held high through reset. A design that got this wrong would freeze as soon as it came out of reset.

A long random stretch checks the enables against a behavioural model on every cycle.

// File: rtl/freeze_seq.sv
module freeze_seq #(
  parameter int READS_NEEDED = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  input  logic cpu_rw,
  input  logic nmi_line_n,
  input  logic release_i,
  output logic ba_oe,
  output logic game_oe,
  output logic exrom_oe,
  output logic nmi_oe
);

  localparam int CW = $clog2(READS_NEEDED + 1);
  localparam logic [CW-1:0] LAST = CW'(READS_NEEDED - 1);

  typedef enum logic [1:0] {IDLE, HALT, MAPPED, FROZEN} st_t;

  st_t st;
  logic sync_a, sync_b, btn_q;
  logic [CW-1:0] reads;

  wire press = sync_b & ~btn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
      btn_q  <= 1'b1;
    end else begin
      sync_a <= btn_i;
      sync_b <= sync_a;
      btn_q  <= sync_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      reads <= '0;
    end else begin
      case (st)
        IDLE: begin
          reads <= '0;
          if (press) st <= HALT;
        end
        HALT: begin
          if (!cpu_rw) reads <= '0;
          else if (reads == LAST) begin
            reads <= '0;
            st    <= MAPPED;
          end else reads <= reads + 1'b1;
        end
        MAPPED: if (nmi_line_n) st <= FROZEN;
        FROZEN: if (release_i) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign ba_oe    = (st == HALT) || (st == MAPPED);
  assign game_oe  = (st == MAPPED) || (st == FROZEN);
  assign nmi_oe   = (st == FROZEN);
  assign exrom_oe = 1'b0;

  AST_NMI_NEEDS_GAME: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_oe |-> game_oe); // R5
  AST_HALT_BEFORE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(game_oe) |-> $past(ba_oe) && $past(ba_oe, 2) && $past(ba_oe, 3)); // R3
  AST_MAP_KEEPS_BA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(game_oe) |-> ba_oe && !nmi_oe); // R4
  AST_NMI_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_oe) |-> $past(nmi_line_n) && !ba_oe); // R6
  AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_oe && !release_i |=> nmi_oe); // R7
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_oe && release_i |=> !nmi_oe && !game_oe && !ba_oe); // R8

endmodule

// File: tb/sim_freeze_seq.sv
`timescale 1ns/1ps
module sim_freeze_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0, btn = 1'b0, rw = 1'b0, rel = 1'b0, nmil = 1'b1;
  logic ba, game, exrom, nmi;
  int checks = 0, errors = 0;
  int ms = 0, rc = 0;
  bit h1 = 1, h2 = 1, h3 = 1;
  bit done = 0;

  always #2 clk = ~clk;

  freeze_seq u0 (.clk(clk), .rst_n(rst_n), .btn_i(btn), .cpu_rw(rw),
    .nmi_line_n(nmil), .release_i(rel), .ba_oe(ba), .game_oe(game),
    .exrom_oe(exrom), .nmi_oe(nmi));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; rc = 0; h1 = 1; h2 = 1; h3 = 1;
    end else begin
      bit pr;
      pr = h2 && !h3;
      h3 = h2; h2 = h1; h1 = btn;
      case (ms)
        0: if (pr) begin ms = 1; rc = 0; end
        1: begin
          rc = rw ? rc + 1 : 0;
          if (rc == 3) ms = 2;
        end
        2: if (nmil) ms = 3;
        default: if (rel) ms = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 model ba", ba, ms == 1 || ms == 2);
    chk("R4 model game", game, ms == 2 || ms == 3);
    chk("R5 model nmi", nmi, ms == 3);
    chk("R4 exrom", exrom, 1'b0);
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    btn = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    chk("R1 ba", ba, 0); chk("R1 game", game, 0); chk("R1 nmi", nmi, 0);
    btn = 1'b0; tick(3);
    btn = 1'b1;
    tick(2); chk("R2 early", ba, 0);
    tick(1); chk("R2 ba", ba, 1);
    nmil = 1'b0;
    rw = 1'b1; tick(2);
    rw = 1'b0; tick(1);
    rw = 1'b1; tick(2);
    chk("R3 broken run", game, 0); chk("R3 ba held", ba, 1);
    tick(1);
    rw = 1'b0;
    chk("R4 game", game, 1); chk("R4 ba", ba, 1); chk("R4 nmi", nmi, 0);
    tick(4);
    chk("R6 nmi", nmi, 0); chk("R6 game", game, 1); chk("R6 ba", ba, 1);
    nmil = 1'b1; tick(1);
    chk("R5 nmi", nmi, 1); chk("R5 ba", ba, 0); chk("R5 game", game, 1);
    btn = 1'b0; tick(3); btn = 1'b1; tick(5);
    chk("R7 ba", ba, 0); tick(10); chk("R7 nmi", nmi, 1);
    rel = 1'b1; tick(1); rel = 1'b0;
    chk("R8 nmi", nmi, 0); chk("R8 game", game, 0); chk("R8 ba", ba, 0);
    btn = 1'b0; tick(3); btn = 1'b1; tick(3);
    chk("R9 ba", ba, 1);
    rel = 1'b1; tick(2); rel = 1'b0;
    chk("R8 ignored in halt", ba, 1);
    rw = 1'b1; tick(3); rw = 1'b0;
    chk("R9 game", game, 1);
    tick(1); chk("R9 nmi", nmi, 1);
    rel = 1'b1; tick(1); rel = 1'b0;
    chk("R8 second release", game, 0);
    for (int i = 0; i < 4000; i++) begin
      btn  = ($urandom % 8) == 0 ? ~btn : btn;
      rw   = ($urandom % 5) != 0;
      nmil = ($urandom % 4) != 0;
      rel  = ($urandom % 16) == 0;
      tick(1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule